// File: doc/BRIEF.md
# Address Decoder with Access Strobes and Reserved-Register Guard

This block sits between an 8-bit processor with a 16-bit address bus and its memory and peripheral devices. From the address, the read/not-write level and the data strobe it produces active-low read and write strobes and chip selects: one for the boot PROM and two for local RAM banks. It raises a request for the external shared bus when the processor touches the public window. It also gives four 2K peripheral selects, and the serial controller owns the first of them. Each select is a single comparison on the raw address bits. No select passes through another decoder, so every select has one level of decode delay.

Some registers of the serial controller put the device into a state that reset cannot clear, and a read is enough to do it. A guard stops those accesses at the decoder. The serial select stays inactive, the read data seen by the processor is forced to all ones, and a registered fault flag pulses for one clock. Internal processor cycles present the top address as a read, which the map sends to the PROM, so those cycles are harmless.

Top module: `busdec_top`

## Requirements
- R1: When address bit 15 is 1 (0x8000 to 0xFFFF), `prom_sel_n` is 0; otherwise it is 1.
- R2: With bit 15 at 0, bits 14:13 = 00 drive `ram_sel_n[0]` low (0x0000 to 0x1FFF) and 01 drive `ram_sel_n[1]` low (0x2000 to 0x3FFF). Each is high at every other address.
- R3: `shared_req` is 1 for addresses 0x4000 to 0x5FFF and 0 for every other address.
- R4: `rd_n` is 0 exactly when `rnw`=1 and `e`=1. `wr_n` is 0 exactly when `rnw`=0 and `e`=1.
- R5: Inside 0x6000 to 0x7FFF, address bits 12:11 = k drive `per_sel_n[k]` low. Slot 0 (0x6000 to 0x67FF) belongs to the serial controller. Outside this region all peripheral selects are high.
- R6: At most one of `prom_sel_n`, `ram_sel_n[*]` and `per_sel_n[*]` is low at any time.
- R7: In slot 0 the register index is address bits 3:0. A read of index 0x2, 0xA or 0xC, or a write of index 0xC, is reserved and keeps `per_sel_n[0]` high. All other indices select the device normally.
- R8: `cpu_rdata` is 0xFF during a reserved read. Otherwise it equals `dev_rdata`.
- R9: `rsv_fault` is 1 for exactly one clock after the first rising edge that samples a reserved access with `e`=1. It stays 0 while the access is held, and it is 0 after synchronous reset.
- R10: An internal cycle (address 0xFFFF, `rnw`=1, `e`=1) selects the PROM with `rd_n` low and no other select or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault flag |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Processor address |
| rnw | input | 1 | 1 = read, 0 = write |
| e | input | 1 | Active-high data strobe |
| dev_rdata | input | DATA_W | Merged read data from the devices |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| prom_sel_n | output | 1 | PROM select, active low |
| ram_sel_n | output | 2 | Local RAM bank selects, active low |
| shared_req | output | 1 | Request for the external shared bus |
| per_sel_n | output | PER_SLOTS | 2K peripheral selects, active low; bit 0 is the serial controller |
| cpu_rdata | output | DATA_W | Read data returned to the processor |
| rsv_fault | output | 1 | One-clock pulse on a blocked reserved access |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, four peripheral slots and a 4-bit register index. These values place every region boundary at the addresses of the fixed map, so the edge addresses of each 8K region and of each 2K slot can each be applied. The 4-bit index lets the bench apply every reserved index in both directions. It also applies reserved indices in peripheral slots other than slot 0, to show that the guard acts only on the serial controller. Held and repeated blocked accesses show that the fault flag fires once on the first blocked cycle and not again while the access is held.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    // Top-level regions chosen by the three highest address bits
    typedef enum logic [2:0] {
        RG_RAM0   = 3'd0,
        RG_RAM1   = 3'd1,
        RG_SHARED = 3'd2,
        RG_PERIPH = 3'd3,
        RG_PROM   = 3'd4
    } region_e;

    localparam int unsigned RAM_BANKS   = 2;
    localparam logic [2:0]  SHARED_CODE = 3'b010;
    localparam logic [2:0]  PERIPH_CODE = 3'b011;

    // Reserved serial-controller register indices
    localparam logic [3:0] RSV_RD_A = 4'h2;
    localparam logic [3:0] RSV_RD_B = 4'hA;
    localparam logic [3:0] RSV_RW   = 4'hC;

    typedef struct packed {
        logic                 prom;
        logic [RAM_BANKS-1:0] ram;
        logic                 shared;
    } mem_hit_t;

    function automatic region_e region_of(input logic [2:0] top3);
        if (top3[2]) return RG_PROM;
        case (top3[1:0])
            2'b00:   return RG_RAM0;
            2'b01:   return RG_RAM1;
            2'b10:   return RG_SHARED;
            default: return RG_PERIPH;
        endcase
    endfunction

    function automatic logic reg_reserved(input logic [3:0] idx, input logic is_read);
        if (is_read) return (idx == RSV_RD_A) || (idx == RSV_RD_B) || (idx == RSV_RW);
        return idx == RSV_RW;
    endfunction

endpackage

// File: rtl/busdec_strobe.sv
module busdec_strobe (
    input  logic rnw,
    input  logic e,
    output logic rd_n,
    output logic wr_n
);
    always_comb begin
        rd_n = ~(rnw & e);
        wr_n = ~(~rnw & e);
    end
endmodule

// File: rtl/busdec_mem_dec.sv
module busdec_mem_dec
    import busdec_pkg::*;
(
    input  logic [2:0] top3,
    output mem_hit_t   hit
);
    // Each hit is one compare on the raw address bits
    always_comb begin
        hit.prom   = top3[2];
        hit.shared = (top3 == SHARED_CODE);
    end

    for (genvar k = 0; k < RAM_BANKS; k++) begin : g_ram
        always_comb hit.ram[k] = (top3 == 3'(k));
    end
endmodule

// File: rtl/busdec_per_dec.sv
module busdec_per_dec
    import busdec_pkg::*;
#(
    parameter int unsigned PER_SLOTS = 4,
    localparam int unsigned SUB_W    = $clog2(PER_SLOTS)
) (
    input  logic [2:0]           top3,
    input  logic [SUB_W-1:0]     sub,
    output logic [PER_SLOTS-1:0] slot_hit
);
    // Region and slot bits are compared together: no cascaded decode
    for (genvar k = 0; k < PER_SLOTS; k++) begin : g_slot
        always_comb slot_hit[k] = ({top3, sub} == {PERIPH_CODE, SUB_W'(k)});
    end
endmodule

// File: rtl/busdec_guard.sv
module busdec_guard
    import busdec_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_hit,
    input  logic [REG_W-1:0]  reg_idx,
    input  logic              rnw,
    input  logic              e,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              blocked,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              fault
);
    logic blocked_act;
    logic prev_q;
    logic fault_q;

    always_comb begin
        blocked     = serial_hit && reg_reserved(4'(reg_idx), rnw);
        blocked_act = blocked && e;
        cpu_rdata   = (blocked && rnw) ? '1 : dev_rdata;
        fault       = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            prev_q  <= blocked_act;
            fault_q <= blocked_act && !prev_q;
        end
    end
endmodule

// File: rtl/busdec_top.sv
module busdec_top
    import busdec_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PER_SLOTS = 4,
    parameter int unsigned REG_W     = 4,
    localparam int unsigned SUB_W    = $clog2(PER_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rnw,
    input  logic                 e,
    input  logic [DATA_W-1:0]    dev_rdata,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 prom_sel_n,
    output logic [1:0]           ram_sel_n,
    output logic                 shared_req,
    output logic [PER_SLOTS-1:0] per_sel_n,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 rsv_fault
);
    logic [2:0]           top3;
    logic [SUB_W-1:0]     sub;
    logic [REG_W-1:0]     reg_idx;
    mem_hit_t             mhit;
    logic [PER_SLOTS-1:0] slot_hit;
    logic                 blocked;

    always_comb begin
        top3    = addr[ADDR_W-1 -: 3];
        sub     = addr[ADDR_W-4 -: SUB_W];
        reg_idx = addr[REG_W-1:0];
    end

    busdec_strobe u_strobe (
        .rnw (rnw),
        .e   (e),
        .rd_n(rd_n),
        .wr_n(wr_n)
    );

    busdec_mem_dec u_mem (
        .top3(top3),
        .hit (mhit)
    );

    busdec_per_dec #(.PER_SLOTS(PER_SLOTS)) u_per (
        .top3    (top3),
        .sub     (sub),
        .slot_hit(slot_hit)
    );

    busdec_guard #(.DATA_W(DATA_W), .REG_W(REG_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .serial_hit(slot_hit[0]),
        .reg_idx   (reg_idx),
        .rnw       (rnw),
        .e         (e),
        .dev_rdata (dev_rdata),
        .blocked   (blocked),
        .cpu_rdata (cpu_rdata),
        .fault     (rsv_fault)
    );

    always_comb begin
        prom_sel_n = ~mhit.prom;
        ram_sel_n  = ~mhit.ram;
        shared_req = mhit.shared;
    end

    for (genvar k = 0; k < PER_SLOTS; k++) begin : g_per_out
        if (k == 0) begin : g_serial
            always_comb per_sel_n[k] = ~(slot_hit[k] && !blocked);
        end else begin : g_plain
            always_comb per_sel_n[k] = ~slot_hit[k];
        end
    end
endmodule

// File: rtl/busdec_chk.sv
module busdec_chk
    import busdec_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PER_SLOTS = 4,
    parameter int unsigned REG_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    addr,
    input logic                 rnw,
    input logic                 e,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 prom_sel_n,
    input logic [1:0]           ram_sel_n,
    input logic                 shared_req,
    input logic [PER_SLOTS-1:0] per_sel_n,
    input logic [DATA_W-1:0]    cpu_rdata,
    input logic                 rsv_fault
);
    logic [2:0] a_top;
    logic       serial_slot;
    logic       rsv_acc;

    always_comb begin
        a_top       = addr[ADDR_W-1 -: 3];
        serial_slot = (a_top == PERIPH_CODE) && (addr[ADDR_W-4 -: $clog2(PER_SLOTS)] == '0);
        rsv_acc     = serial_slot && reg_reserved(4'(addr[REG_W-1:0]), rnw);
    end

    p_prom_upper_r1: assert property (@(posedge clk) disable iff (rst)
        a_top[2] |-> !prom_sel_n);

    p_shared_window_r3: assert property (@(posedge clk) disable iff (rst)
        shared_req == (a_top == SHARED_CODE));

    p_strobe_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !e |-> (rd_n && wr_n));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_one_select_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~prom_sel_n, ~ram_sel_n, ~per_sel_n}));

    p_guard_select_r7: assert property (@(posedge clk) disable iff (rst)
        rsv_acc |-> per_sel_n[0]);

    p_guard_data_r8: assert property (@(posedge clk) disable iff (rst)
        (rsv_acc && rnw) |-> (cpu_rdata == '1));

    p_fault_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsv_fault |=> !rsv_fault);

    p_fault_cause_r9: assert property (@(posedge clk) disable iff (rst)
        rsv_fault |-> $past(rsv_acc && e));
endmodule

bind busdec_top busdec_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_SLOTS(PER_SLOTS), .REG_W(REG_W)
) chk_i (
    .clk(clk), .rst(rst), .addr(addr), .rnw(rnw), .e(e),
    .rd_n(rd_n), .wr_n(wr_n), .prom_sel_n(prom_sel_n), .ram_sel_n(ram_sel_n),
    .shared_req(shared_req), .per_sel_n(per_sel_n), .cpu_rdata(cpu_rdata),
    .rsv_fault(rsv_fault)
);

// File: tb/busdec_tb.sv
module busdec_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        rnw = 1'b1;
    logic        e = 1'b0;
    logic [7:0]  dev_rdata = 8'h5A;
    logic        rd_n, wr_n, prom_sel_n, shared_req, rsv_fault;
    logic [1:0]  ram_sel_n;
    logic [3:0]  per_sel_n;
    logic [7:0]  cpu_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busdec_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rnw(rnw), .e(e), .dev_rdata(dev_rdata),
        .rd_n(rd_n), .wr_n(wr_n), .prom_sel_n(prom_sel_n), .ram_sel_n(ram_sel_n),
        .shared_req(shared_req), .per_sel_n(per_sel_n), .cpu_rdata(cpu_rdata),
        .rsv_fault(rsv_fault)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (addr %h rnw %b e %b)",
                     req, what, act, exp, addr, rnw, e);
        end
    endtask

    // Reference: {prom_n, ram_n[1:0], shared, per_n[3:0]} from the requirements
    function automatic logic [7:0] model_sel(input logic [15:0] a, input logic rd);
        logic       up = a[15];
        logic [1:0] r  = a[14:13];
        logic [1:0] s  = a[12:11];
        logic [3:0] ix = a[3:0];
        logic       rsv = rd ? (ix == 4'h2 || ix == 4'hA || ix == 4'hC) : (ix == 4'hC);
        logic [3:0] per_n;
        for (int k = 0; k < 4; k++) begin
            logic hit = !up && r == 2'd3 && s == 2'(k);
            if (k == 0 && rsv) hit = 1'b0;
            per_n[k] = !hit;
        end
        return {up ? 1'b0 : 1'b1, !(!up && r == 2'd1), !(!up && r == 2'd0),
                !up && r == 2'd2, per_n};
    endfunction

    function automatic logic model_rsv_read(input logic [15:0] a, input logic rd);
        return rd && a[15:11] == 5'b01100 &&
               (a[3:0] == 4'h2 || a[3:0] == 4'hA || a[3:0] == 4'hC);
    endfunction

    task automatic drive(input logic [15:0] a, input logic rd, input logic en);
        @(negedge clk);
        addr = a; rnw = rd; e = en;
        #1;
    endtask

    task automatic check_map(input string req);
        logic [7:0] ex = model_sel(addr, rnw);
        chk(req, "prom_sel_n", 16'(prom_sel_n), 16'(ex[7]));
        chk(req, "ram_sel_n",  16'(ram_sel_n),  16'(ex[6:5]));
        chk(req, "shared_req", 16'(shared_req), 16'(ex[4]));
        chk(req, "per_sel_n",  16'(per_sel_n),  16'(ex[3:0]));
    endtask

    task automatic t_reset;
        drive(16'h6002, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R9", "fault during reset", 16'(rsv_fault), 16'h0);
        drive(16'h0000, 1'b1, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R9", "fault after reset", 16'(rsv_fault), 16'h0);
    endtask

    task automatic t_map_sweep;
        logic [15:0] pts [16] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF,
                                 16'h4000, 16'h5FFF, 16'h6000, 16'h67FF,
                                 16'h6800, 16'h6FFF, 16'h7000, 16'h7800,
                                 16'h7FFF, 16'h8000, 16'hC123, 16'hFFF8};
        for (int i = 0; i < 16; i++) begin
            drive(pts[i], 1'b0, 1'b1);
            check_map("R1 R2 R3 R5 R6");
            chk("R6", "one select", 16'($countones({~prom_sel_n, ~ram_sel_n, ~per_sel_n}) <= 1), 16'h1);
        end
    endtask

    task automatic t_internal_cycle;
        drive(16'hFFFF, 1'b1, 1'b1);
        check_map("R10");
        chk("R10", "rd_n", 16'(rd_n), 16'h0);
        chk("R10", "wr_n", 16'(wr_n), 16'h1);
    endtask

    task automatic t_strobes;
        for (int m = 0; m < 4; m++) begin
            drive(16'h2345, m[0], m[1]);
            chk("R4", "rd_n", 16'(rd_n), 16'(!(m[0] && m[1])));
            chk("R4", "wr_n", 16'(wr_n), 16'(!(!m[0] && m[1])));
        end
    endtask

    task automatic t_guard;
        logic [15:0] bases [3] = '{16'h6000, 16'h6010, 16'h6800};
        dev_rdata = 8'h3C;
        for (int b = 0; b < 3; b++) begin
            for (int ix = 0; ix < 16; ix++) begin
                for (int d = 0; d < 2; d++) begin
                    drive(bases[b] | 16'(ix), d[0], 1'b1);
                    check_map("R7");
                    chk("R8", "cpu_rdata", 16'(cpu_rdata),
                        model_rsv_read(addr, rnw) ? 16'h00FF : 16'h003C);
                end
            end
        end
        dev_rdata = 8'h5A;
    endtask

    task automatic t_fault;
        drive(16'h0000, 1'b1, 1'b0);
        @(posedge clk); #1;
        chk("R9", "idle", 16'(rsv_fault), 16'h0);
        // blocked access without strobe: no fault
        drive(16'h600A, 1'b1, 1'b0);
        @(posedge clk); #1;
        chk("R9", "no strobe", 16'(rsv_fault), 16'h0);
        // strobe rises on a reserved read: one pulse then quiet while held
        drive(16'h600A, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R9", "first edge", 16'(rsv_fault), 16'h1);
        @(posedge clk); #1;
        chk("R9", "held", 16'(rsv_fault), 16'h0);
        // allowed access in between
        drive(16'h6003, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R9", "allowed reg", 16'(rsv_fault), 16'h0);
        // reserved write to index C
        drive(16'h600C, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R9", "reserved write", 16'(rsv_fault), 16'h1);
        // write to a read-only-reserved index is allowed
        drive(16'h6002, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R9", "write idx 2", 16'(rsv_fault), 16'h0);
        // reserved index in slot 1 is not guarded
        drive(16'h680C, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R9", "slot 1", 16'(rsv_fault), 16'h0);
        // back-to-back reserved after an allowed cycle fires again
        drive(16'h6002, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R9", "re-arm", 16'(rsv_fault), 16'h1);
        drive(16'h0000, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_map_sweep();
        t_internal_cycle();
        t_strobes();
        t_guard();
        t_fault();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule